// File: doc/BRIEF.md
# Thermal Throttle and Interrupt Controller

This block watches a stream of signed 8-bit temperature samples. Each sample is compared against two programmable thresholds: a warning (high) limit and a critical limit. When a sample goes past the critical limit, the block pulls a shared active-low throttle line. The line stays pulled until the temperature has cooled by a fixed hysteresis margin, which is 5 degrees by default. The block can also command the cooling fan to full speed. Both thresholds feed an active-low interrupt line. Software releases that line by reading status.

After a critical interrupt, that source stays quiet until the temperature has dropped through the hysteresis band. This keeps the host from being flooded with repeat interrupts. The throttle line is bidirectional. When the block is not driving it and another agent pulls it low, the fan is forced to full speed. The fan-link enable bit has no say in that case.

The block is used beside a temperature sensor front end. The valid strobe marks one monitoring cycle. Software owns the limit and enable inputs.

Top module: `thermal_guard`

## Requirements
- R1: A sample with `temp_valid`=1 whose signed value is strictly greater than the signed `crit_limit` sets `thr_drive_en` to 1 at the next clock edge. A sample equal to the limit does not set it.
- R2: Once set, `thr_drive_en` stays 1 until a sample arrives whose value is less than or equal to the release floor, which is `crit_limit` minus `HYST_DEG`. That sample clears `thr_drive_en` at the next edge.
- R3: While the block drives the throttle line, `fan_full` is 1 if `fan_link_en`=1 and 0 if `fan_link_en`=0.
- R4: If `thr_drive_en`=0 and `thr_pin_in`=0 at an edge, `fan_full` is 1 after that edge, whatever the value of `fan_link_en`. While the block itself drives the line, a low `thr_pin_in` has no effect on `fan_full`.
- R5: A sample strictly greater than `high_limit`, with `high_irq_en`=1, drives `irq_n` to 0 at the next edge. Every later sample that is still above the limit raises it again.
- R6: A sample strictly greater than `crit_limit`, with `crit_irq_en`=1 and the critical source armed, drives `irq_n` to 0 at the next edge.
- R7: A `status_rd` pulse clears all pending sources, so `irq_n` is 1 after that edge, and it leaves `thr_drive_en` unchanged. If a source sets in the same cycle as the read, the set wins.
- R8: Raising a critical interrupt disarms that source. It re-arms only on a sample at or below the release floor. Arming is used up only when an interrupt is actually raised.
- R9: Clearing `high_irq_en` or `crit_irq_en` clears that source's pending interrupt at the next edge, and blocks new ones from it for as long as the enable is 0.
- R10: The release floor saturates at -128. With `crit_limit` = -126, a sample of -127 keeps the throttle line driven and a sample of -128 releases it.
- R11: After reset, `irq_n`=1, `thr_drive_en`=0 and `fan_full`=0, and the critical source is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Marks one monitoring sample |
| temp_reading | input | 8 | Signed temperature in degrees |
| high_limit | input | 8 | Signed warning threshold |
| crit_limit | input | 8 | Signed critical threshold |
| fan_link_en | input | 1 | Lets self-driven throttling force the fan to full speed |
| high_irq_en | input | 1 | Enables the warning interrupt source |
| crit_irq_en | input | 1 | Enables the critical interrupt source |
| status_rd | input | 1 | One-cycle status read pulse |
| thr_pin_in | input | 1 | Sensed level of the shared throttle line |
| thr_drive_en | output | 1 | 1 drives the throttle line low |
| irq_n | output | 1 | Active-low interrupt |
| fan_full | output | 1 | Fan full-speed command |

## Verification
The comparisons are driven with samples equal to the limit and one degree above it, which separates strict from non-strict comparison. Negative limits against positive samples separate signed from unsigned comparison. Samples inside the hysteresis band, at its floor, and at a floor clamped to -128 separate correct release from early release and from wrapped subtraction. The interrupt sequences place reads, repeated over-limit samples, enable toggles and a read that coincides with a new event. Together these tell re-arming, persistence and masking apart, and the external pull is applied both with the block driving the line and with it idle.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  localparam int TEMP_W = 8;
  localparam int WIDE_W = TEMP_W + 2;
  typedef logic signed [TEMP_W-1:0] temp_t;
  typedef logic signed [WIDE_W-1:0] wide_t;
  localparam wide_t TEMP_MIN_W = wide_t'(-(2 ** (TEMP_W - 1)));

  // interrupt source indices
  localparam int SRC_HIGH = 0;
  localparam int SRC_CRIT = 1;
  localparam int SRC_N    = 2;

  function automatic logic exceeds(input temp_t sample, input temp_t lim);
    return sample > lim;
  endfunction

  // limit minus hysteresis, clamped to the most negative temperature
  function automatic temp_t release_floor(input temp_t lim, input logic [TEMP_W-1:0] hyst);
    wide_t diff;
    diff = wide_t'(lim) - $signed({2'b00, hyst});
    if (diff < TEMP_MIN_W) return temp_t'(TEMP_MIN_W);
    return temp_t'(diff);
  endfunction
endpackage

// File: rtl/thermal_guard_cmp.sv
module thermal_guard_cmp
  import thermal_guard_pkg::*;
#(
  parameter int HYST_DEG = 5
) (
  input  temp_t temp_reading,
  input  temp_t high_limit,
  input  temp_t crit_limit,
  output logic  over_high,
  output logic  over_crit,
  output logic  at_release
);
  localparam logic [TEMP_W-1:0] HYST_V = TEMP_W'(HYST_DEG);

  temp_t floor_v;

  always_comb begin
    floor_v    = release_floor(crit_limit, HYST_V);
    over_high  = exceeds(temp_reading, high_limit);
    over_crit  = exceeds(temp_reading, crit_limit);
    at_release = !exceeds(temp_reading, floor_v);
  end
endmodule

// File: rtl/thermal_guard_throttle.sv
module thermal_guard_throttle (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic over_crit,
  input  logic at_release,
  input  logic fan_link_en,
  input  logic pin_in,
  output logic drive_en,
  output logic fan_full
);
  logic active_q;
  logic ext_pull_q;
  logic ext_pull_now;

  assign ext_pull_now = !active_q && !pin_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (sample && over_crit) begin
      active_q <= 1'b1;
    end else if (sample && at_release) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_pull_q <= 1'b0;
    else        ext_pull_q <= ext_pull_now;
  end

  assign drive_en = active_q;
  assign fan_full = (active_q && fan_link_en) || ext_pull_q;

  AST_THR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sample && over_crit |=> drive_en); // R1
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en && !(sample && at_release) |=> drive_en); // R2
  AST_THR_FAN_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en && fan_link_en |-> fan_full); // R3
endmodule

// File: rtl/thermal_guard_irq.sv
module thermal_guard_irq
  import thermal_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic over_high,
  input  logic over_crit,
  input  logic at_release,
  input  logic high_irq_en,
  input  logic crit_irq_en,
  input  logic status_rd,
  output logic irq_n
);
  logic [SRC_N-1:0] hit;
  logic [SRC_N-1:0] en_v;
  logic [SRC_N-1:0] armed_q;
  logic [SRC_N-1:0] set_ev;
  logic [SRC_N-1:0] pend_q;

  assign hit[SRC_HIGH]  = over_high;
  assign hit[SRC_CRIT]  = over_crit;
  assign en_v[SRC_HIGH] = high_irq_en;
  assign en_v[SRC_CRIT] = crit_irq_en;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign set_ev[g] = sample && hit[g] && en_v[g] && armed_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            pend_q[g] <= 1'b0;
      else if (!en_v[g])     pend_q[g] <= 1'b0;
      else if (set_ev[g])    pend_q[g] <= 1'b1;
      else if (status_rd)    pend_q[g] <= 1'b0;
    end

    if (g == SRC_CRIT) begin : g_hyst_arm
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    armed_q[g] <= 1'b1;
        else if (set_ev[g])            armed_q[g] <= 1'b0;
        else if (sample && at_release) armed_q[g] <= 1'b1;
      end
    end else begin : g_always_arm
      assign armed_q[g] = 1'b1;
    end
  end

  assign irq_n = !(|pend_q);

  AST_HIGH_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample && over_high && high_irq_en |=> !irq_n); // R5
  AST_CRIT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q[SRC_CRIT]) |-> $past(armed_q[SRC_CRIT])); // R8
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !(|set_ev) |=> irq_n); // R7
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !high_irq_en && !crit_irq_en |=> irq_n); // R9
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int HYST_DEG = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       temp_valid,
  input  logic [7:0] temp_reading,
  input  logic [7:0] high_limit,
  input  logic [7:0] crit_limit,
  input  logic       fan_link_en,
  input  logic       high_irq_en,
  input  logic       crit_irq_en,
  input  logic       status_rd,
  input  logic       thr_pin_in,
  output logic       thr_drive_en,
  output logic       irq_n,
  output logic       fan_full
);
  logic over_high;
  logic over_crit;
  logic at_release;

  thermal_guard_cmp #(.HYST_DEG(HYST_DEG)) cmp_i (
    .temp_reading (temp_t'(temp_reading)),
    .high_limit   (temp_t'(high_limit)),
    .crit_limit   (temp_t'(crit_limit)),
    .over_high    (over_high),
    .over_crit    (over_crit),
    .at_release   (at_release)
  );

  thermal_guard_throttle thr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample      (temp_valid),
    .over_crit   (over_crit),
    .at_release  (at_release),
    .fan_link_en (fan_link_en),
    .pin_in      (thr_pin_in),
    .drive_en    (thr_drive_en),
    .fan_full    (fan_full)
  );

  thermal_guard_irq irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample      (temp_valid),
    .over_high   (over_high),
    .over_crit   (over_crit),
    .at_release  (at_release),
    .high_irq_en (high_irq_en),
    .crit_irq_en (crit_irq_en),
    .status_rd   (status_rd),
    .irq_n       (irq_n)
  );

  AST_EXT_FAN: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_drive_en && !thr_pin_in |=> fan_full || (thr_drive_en && !fan_link_en)); // R4
  AST_CRIT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    temp_valid && over_crit && crit_irq_en && !thr_drive_en |=> !irq_n); // R6
  AST_READ_KEEPS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !temp_valid |=> $stable(thr_drive_en)); // R7
endmodule

// File: tb/thermal_guard_tb_top.sv
`timescale 1ns/1ps
module thermal_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_valid = 1'b0;
  logic [7:0] temp_reading = 8'd0;
  logic [7:0] high_limit = 8'sd127;
  logic [7:0] crit_limit = 8'sd80;
  logic fan_link_en = 1'b1;
  logic high_irq_en = 1'b1;
  logic crit_irq_en = 1'b1;
  logic status_rd = 1'b0;
  logic ext_pull = 1'b0;
  logic thr_pin_in;
  logic thr_drive_en, irq_n, fan_full;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // open-drain line: low if the block or the outside agent pulls it
  assign thr_pin_in = !(thr_drive_en || ext_pull);

  thermal_guard dut_i (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_reading(temp_reading),
    .high_limit(high_limit), .crit_limit(crit_limit), .fan_link_en(fan_link_en),
    .high_irq_en(high_irq_en), .crit_irq_en(crit_irq_en), .status_rd(status_rd),
    .thr_pin_in(thr_pin_in), .thr_drive_en(thr_drive_en), .irq_n(irq_n), .fan_full(fan_full)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int t);
    @(negedge clk);
    temp_reading = 8'(t);
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 irq_n", irq_n, 1'b1);
    chk("R11 drive", thr_drive_en, 1'b0);
    chk("R11 fan", fan_full, 1'b0);
  endtask

  task automatic t_crit_path();
    crit_limit = 8'sd80;
    push(80);  chk("R1 equal no throttle", thr_drive_en, 1'b0);
    chk("R1 equal no irq", irq_n, 1'b1);
    push(81);  chk("R1 throttle", thr_drive_en, 1'b1);
    chk("R6 crit irq", irq_n, 1'b0);
    chk("R3 fan linked", fan_full, 1'b1);
    rd();      chk("R7 read releases irq", irq_n, 1'b1);
    chk("R7 read keeps throttle", thr_drive_en, 1'b1);
    push(76);  chk("R2 hold in band", thr_drive_en, 1'b1);
    push(85);  chk("R8 no irq unarmed", irq_n, 1'b1);
    push(75);  chk("R2 release at floor", thr_drive_en, 1'b0);
    chk("R3 fan off", fan_full, 1'b0);
    push(81);  chk("R8 rearmed irq", irq_n, 1'b0);
    rd();
    push(60);  chk("R2 released", thr_drive_en, 1'b0);
  endtask

  task automatic t_signed();
    crit_limit = 8'(-10);
    push(5);   chk("R1 signed compare", thr_drive_en, 1'b1);
    rd();
    push(-14); chk("R2 hold negative", thr_drive_en, 1'b1);
    push(-15); chk("R2 release negative", thr_drive_en, 1'b0);
  endtask

  task automatic t_sat();
    crit_limit = 8'(-126);
    push(-125); chk("R10 set", thr_drive_en, 1'b1);
    rd();
    push(-127); chk("R10 no wrap release", thr_drive_en, 1'b1);
    push(-128); chk("R10 clamp release", thr_drive_en, 1'b0);
    crit_limit = 8'sd80;
  endtask

  task automatic t_fan_off();
    fan_link_en = 1'b0;
    push(90);  chk("R3 throttle unlinked", thr_drive_en, 1'b1);
    chk("R3 fan not forced", fan_full, 1'b0);
    @(negedge clk); ext_pull = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 pull ignored while driving", fan_full, 1'b0);
    ext_pull = 1'b0;
    rd();
    push(0);   chk("R2 release", thr_drive_en, 1'b0);
  endtask

  task automatic t_ext();
    fan_link_en = 1'b0;
    @(negedge clk); ext_pull = 1'b1;
    @(negedge clk);
    chk("R4 external pull forces fan", fan_full, 1'b1);
    chk("R4 block not driving", thr_drive_en, 1'b0);
    ext_pull = 1'b0;
    @(negedge clk);
    chk("R4 fan drops after pull", fan_full, 1'b0);
    fan_link_en = 1'b1;
  endtask

  task automatic t_high();
    high_limit = 8'sd50; crit_limit = 8'sd100;
    push(50);  chk("R5 equal no irq", irq_n, 1'b1);
    push(51);  chk("R5 high irq", irq_n, 1'b0);
    rd();      chk("R7 read", irq_n, 1'b1);
    push(52);  chk("R5 persists", irq_n, 1'b0);
    rd();
    push(50);  chk("R5 below no irq", irq_n, 1'b1);
    // read in the same cycle as a new event: event wins
    @(negedge clk);
    temp_reading = 8'sd60; temp_valid = 1'b1; status_rd = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0; status_rd = 1'b0;
    chk("R7 set beats read", irq_n, 1'b0);
    rd();
  endtask

  task automatic t_mask();
    push(60);  chk("R9 pending", irq_n, 1'b0);
    @(negedge clk); high_irq_en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears", irq_n, 1'b1);
    push(70);  chk("R9 masked", irq_n, 1'b1);
    high_irq_en = 1'b1;
    push(40);  chk("R9 no stale", irq_n, 1'b1);
    high_limit = 8'sd127; crit_limit = 8'sd100;
    crit_irq_en = 1'b0;
    push(110); chk("R9 crit masked irq", irq_n, 1'b1);
    chk("R9 throttle still acts", thr_drive_en, 1'b1);
    crit_irq_en = 1'b1;
    push(111); chk("R8 arm not consumed by mask", irq_n, 1'b0);
    rd();
    push(0);   chk("R2 release", thr_drive_en, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crit_path();
    t_signed();
    t_sat();
    t_fan_off();
    t_ext();
    t_high();
    t_mask();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule